// File: doc/BRIEF.md
# Fewest-in-flight thread fetch selector

This block decides, every clock, which hardware thread of a simultaneous-multithreading front end owns the single shared fetch port. It keeps one counter per thread holding the number of instructions that thread has in the pipeline. The counter rises with the instructions fetched for it, falls with those retired, and drops by a squash count when that thread alone is flushed. The eligible thread with the smallest count receives a one-hot grant. A stalled thread therefore piles up in-flight work and loses fetch until it drains, rather than being handed fetch slots in blind rotation.

A thread is eligible only when its enable bit is set, it is awake, and its count is below a per-thread cap. The cap stands in for that thread's share of partitioned back-end buffers. When two or more eligible threads have the same lowest count, the tie goes to the first of them in rotation order, starting just after the previous winner. A spinning thread can be put to sleep with a quiesce request that records a watch address. It stays ineligible until a store to exactly that address is observed.

Top module: `smt_fetch_picker`

## Requirements
- R1: After a synchronous active-low reset every counter is zero, no thread sleeps, and rotation starts at thread 0, so with all threads enabled the first grant goes to thread 0.
- R2: The grant goes to the eligible thread with the strictly lowest in-flight count, evaluated from the counts held at the start of the cycle.
- R3: Among eligible threads tied at the lowest count, the first in the order last+1, last+2, ... (modulo the thread count) wins, where last is the most recent granted thread. The record of the last winner is unchanged in a cycle with no grant.
- R4: A thread's counter becomes count + fetched - retired at the next clock edge. A cycle with fetch and retire both zero and no flush leaves it unchanged.
- R5: A flush of a thread subtracts its squash count in the same update as that cycle's fetch and retire, and the result is clamped at zero.
- R6: A thread whose count is greater than or equal to its cap input is not granted.
- R7: A thread whose enable bit is low is not granted.
- R8: A quiesce request for a thread records the quiesce address and makes the thread ineligible from the next cycle. A store to any other address leaves it asleep. A store to the recorded address wakes it from the cycle after the store.
- R9: When no thread is eligible, the grant vector is all zeros.
- R10: The grant has at most one bit set, and only for an eligible thread. If any thread is eligible, exactly one bit is set.
- R11: A counter saturates at its maximum value (all ones) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_en | input | NTHR | Per-thread fetch enable |
| fetch_num | input | NTHR*FET_W | Instructions fetched this cycle, per thread |
| retire_num | input | NTHR*FET_W | Instructions retired this cycle, per thread |
| flush_en | input | NTHR | Per-thread flush strobe |
| flush_num | input | NTHR*CNT_W | Instructions squashed by the flush, per thread |
| cap_lim | input | NTHR*CNT_W | Per-thread in-flight cap |
| qsc_req | input | NTHR | Per-thread quiesce request |
| qsc_addr | input | ADDR_W | Address to watch for a quiesce request |
| st_vld | input | 1 | Snooped store valid |
| st_addr | input | ADDR_W | Snooped store address |
| grant | output | NTHR | One-hot fetch grant, zero when none is eligible |

## Verification
The bench builds the block with four threads, 4-bit counters, 3-bit fetch and retire counts and 8-bit addresses. The narrow counter lets two fetches of seven reach saturation at 15. It also makes the cap comparison easy to probe: enabling one thread with a cap of 1 exposes whether its count is zero. Four threads give a full rotation for tie-breaking and leave room to sleep one thread while a neighbour still wins. The 8-bit watch address keeps a mismatching store and a matching store easy to tell apart.

// File: rtl/smt_pick_pkg.sv
// smt_pick_pkg: shared helpers for the fetch selector.
// Assumes: values fit in a 32-bit int before clamping.
package smt_pick_pkg;

    // Clamp a signed value into the range [0, hi].
    function automatic int sat_range(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/smt_pick_ctr.sv
// smt_pick_ctr: in-flight instruction counter for one thread.
// Adds fetched instructions and subtracts retired and flushed ones in a
// single update. The result saturates at zero and at all ones.
// Assumes: all three inputs apply to this thread in the current cycle.
module smt_pick_ctr #(
    parameter int CNT_W = 6,
    parameter int FET_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FET_W-1:0] fetch_n,
    input  logic [FET_W-1:0] retire_n,
    input  logic             flush_v,
    input  logic [CNT_W-1:0] flush_n,
    output logic [CNT_W-1:0] cnt
);
    import smt_pick_pkg::*;

    localparam int CMAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt_d;
    logic             idle;
    logic             drain_all;

    // Combine this cycle's fetch, retire and flush into the next count.
    always_comb begin
        int sum;
        sum = int'(cnt) + int'(fetch_n) - int'(retire_n);
        if (flush_v) sum = sum - int'(flush_n);
        cnt_d = CNT_W'(sat_range(sum, CMAX));
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_d;
    end

    // Flags used only by the checks below.
    assign idle      = (fetch_n == '0) && (retire_n == '0) && !flush_v;
    assign drain_all = flush_v && (int'(flush_n) >= int'(cnt) + int'(fetch_n));

    // R4
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(cnt));

    // R5
    flush_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_all |=> (cnt == '0));

    // R11
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == CNT_W'(CMAX)) && (retire_n == '0) && !flush_v) |=> (cnt == CNT_W'(CMAX)));

endmodule

// File: rtl/smt_pick_sleep.sv
// smt_pick_sleep: quiesce state for one thread.
// A request sets the sleep flag and records the watch address. A store
// whose address equals the recorded one clears the flag. If a request
// and a matching store arrive in the same cycle, the request wins.
// Assumes: store addresses are compared in full, with no masking.
module smt_pick_sleep #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              st_vld,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              asleep
);
    logic [ADDR_W-1:0] watch;
    logic              hit;

    // Detect a store to the watched location.
    assign hit = st_vld && (st_addr == watch);

    // Track sleep state and the address it waits on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asleep <= 1'b0;
            watch  <= '0;
        end else if (req) begin
            asleep <= 1'b1;
            watch  <= req_addr;
        end else if (hit) begin
            asleep <= 1'b0;
        end
    end

    // R8
    sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !req && !(st_vld && st_addr == watch)) |=> asleep);

    // R8
    wake_on_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !req && st_vld && st_addr == watch) |=> !asleep);

    // R8
    req_sleeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> asleep);

endmodule

// File: rtl/smt_pick_arb.sv
// smt_pick_arb: lowest-count arbiter with rotating tie-break.
// Scans the threads starting just after the last winner and keeps the
// first one with a strictly smaller count. Among equal lowest counts this
// picks the earliest in rotation order.
// Assumes: NTHR >= 2, and elig is already fully qualified.
module smt_pick_arb #(
    parameter int NTHR  = 4,
    parameter int CNT_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       elig,
    input  logic [NTHR*CNT_W-1:0] cnts,
    output logic [NTHR-1:0]       grant
);
    localparam int IDX_W = $clog2(NTHR);

    logic [CNT_W-1:0] cnt_a [NTHR];
    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] win_idx;
    logic [CNT_W-1:0] win_cnt;
    logic             found;

    for (genvar i = 0; i < NTHR; i++) begin : g_unpack
        assign cnt_a[i] = cnts[i*CNT_W +: CNT_W];
    end

    // Rotating scan for the lowest count among eligible threads.
    always_comb begin
        int idx;
        found   = 1'b0;
        win_idx = '0;
        win_cnt = '0;
        grant   = '0;
        for (int k = 1; k <= NTHR; k++) begin
            idx = (int'(last) + k) % NTHR;
            if (elig[idx] && (!found || cnt_a[idx] < win_cnt)) begin
                found   = 1'b1;
                win_cnt = cnt_a[idx];
                win_idx = IDX_W'(idx);
            end
        end
        if (found) grant[win_idx] = 1'b1;
    end

    // Remember the most recent winner for tie-breaking.
    always_ff @(posedge clk) begin
        if (!rst_n)     last <= IDX_W'(NTHR - 1);
        else if (found) last <= win_idx;
    end

    // R10
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~elig) == '0));

    // R9
    grant_when_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((elig != '0) == (grant != '0)));

    // R3
    last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> $stable(last));

    for (genvar j = 0; j < NTHR; j++) begin : g_min_chk
        // R2
        lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((grant != '0) && elig[j]) |-> (win_cnt <= cnt_a[j]));
    end

endmodule

// File: rtl/smt_fetch_picker.sv
// smt_fetch_picker: per-cycle fetch thread selector for an SMT front end.
// Holds one in-flight counter and one quiesce tracker per thread. A thread
// is eligible when it is enabled, awake and below its cap. The eligible
// thread with the fewest in-flight instructions gets the grant.
// Assumes: the grant is combinational from registered state and the
// per-cycle enable and cap inputs; counts reported for a cycle take
// effect at the next edge.
module smt_fetch_picker #(
    parameter int NTHR   = 4,
    parameter int CNT_W  = 6,
    parameter int FET_W  = 3,
    parameter int ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTHR-1:0]       thr_en,
    input  logic [NTHR*FET_W-1:0] fetch_num,
    input  logic [NTHR*FET_W-1:0] retire_num,
    input  logic [NTHR-1:0]       flush_en,
    input  logic [NTHR*CNT_W-1:0] flush_num,
    input  logic [NTHR*CNT_W-1:0] cap_lim,
    input  logic [NTHR-1:0]       qsc_req,
    input  logic [ADDR_W-1:0]     qsc_addr,
    input  logic                  st_vld,
    input  logic [ADDR_W-1:0]     st_addr,
    output logic [NTHR-1:0]       grant
);
    logic [NTHR*CNT_W-1:0] cnt_bus;
    logic [NTHR-1:0]       asleep;
    logic [NTHR-1:0]       elig;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        logic [CNT_W-1:0] cnt_t;
        logic [CNT_W-1:0] cap_t;

        smt_pick_ctr #(.CNT_W(CNT_W), .FET_W(FET_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .fetch_n  (fetch_num[t*FET_W +: FET_W]),
            .retire_n (retire_num[t*FET_W +: FET_W]),
            .flush_v  (flush_en[t]),
            .flush_n  (flush_num[t*CNT_W +: CNT_W]),
            .cnt      (cnt_t)
        );

        smt_pick_sleep #(.ADDR_W(ADDR_W)) u_sleep (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (qsc_req[t]),
            .req_addr (qsc_addr),
            .st_vld   (st_vld),
            .st_addr  (st_addr),
            .asleep   (asleep[t])
        );

        // Qualify this thread: enabled, awake, and below its cap.
        assign cap_t   = cap_lim[t*CNT_W +: CNT_W];
        assign elig[t] = thr_en[t] && !asleep[t] && (cnt_t < cap_t);
        assign cnt_bus[t*CNT_W +: CNT_W] = cnt_t;

        // R6
        cap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> (cnt_t < cap_t));

        // R7
        enable_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> thr_en[t]);

        // R8
        sleep_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[t] |-> !asleep[t]);
    end

    smt_pick_arb #(.NTHR(NTHR), .CNT_W(CNT_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .elig  (elig),
        .cnts  (cnt_bus),
        .grant (grant)
    );

endmodule

// File: tb/smt_fetch_picker_tb.sv
`timescale 1ns/1ps
// smt_fetch_picker_tb: table-driven checks followed by directed corner tests.
module smt_fetch_picker_tb;
    localparam int NT = 4;
    localparam int CW = 4;
    localparam int FW = 3;
    localparam int AW = 8;

    typedef struct packed {
        logic [3:0] mask;
        logic [1:0] ft;
        logic [2:0] fn;
        logic [1:0] rt;
        logic [2:0] rn;
        logic       fv;
        logic [1:0] flt;
        logic [3:0] fln;
        logic [3:0] eg;
    } vec_t;

    // Each row: enable, fetch thread/num, retire thread/num, flush, expected grant.
    localparam int NV = 15;
    localparam vec_t VT [NV] = '{
        '{4'hF, 2'd0, 3'd4, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0001}, // R1 R2: start at t0
        '{4'hF, 2'd1, 3'd3, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0010}, // R3 R4
        '{4'hF, 2'd2, 3'd2, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0100}, // R3
        '{4'hF, 2'd3, 3'd5, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b1000}, // R2
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd3, 1'b0, 2'd0, 4'd0, 4'b0100}, // R2: counts 4,3,2,5
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0001}, // R4: t0 retired to 1
        '{4'hE, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0100}, // R7: t0 disabled
        '{4'hF, 2'd2, 3'd1, 2'd0, 3'd0, 1'b1, 2'd1, 4'd7, 4'b0001}, // R5: flush t1 by 7
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0010}, // R5: t1 clamped at 0
        '{4'hF, 2'd0, 3'd1, 2'd0, 3'd1, 1'b0, 2'd0, 4'd0, 4'b0010}, // R4: net zero on t0
        '{4'h0, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0000}, // R9: none enabled
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd1, 1'b0, 2'd0, 4'd0, 4'b0010}, // R2
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0001}, // R3: tie t0/t1, last t1
        '{4'hF, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0010}, // R3: tie, last t0
        '{4'hC, 2'd0, 3'd0, 2'd0, 3'd0, 1'b0, 2'd0, 4'd0, 4'b0100}  // R2 R7: t2 3 vs t3 5
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NT-1:0]     thr_en;
    logic [NT*FW-1:0]  fetch_num;
    logic [NT*FW-1:0]  retire_num;
    logic [NT-1:0]     flush_en;
    logic [NT*CW-1:0]  flush_num;
    logic [NT*CW-1:0]  cap_lim;
    logic [NT-1:0]     qsc_req;
    logic [AW-1:0]     qsc_addr;
    logic              st_vld;
    logic [AW-1:0]     st_addr;
    logic [NT-1:0]     grant;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    smt_fetch_picker #(.NTHR(NT), .CNT_W(CW), .FET_W(FW), .ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .thr_en     (thr_en),
        .fetch_num  (fetch_num),
        .retire_num (retire_num),
        .flush_en   (flush_en),
        .flush_num  (flush_num),
        .cap_lim    (cap_lim),
        .qsc_req    (qsc_req),
        .qsc_addr   (qsc_addr),
        .st_vld     (st_vld),
        .st_addr    (st_addr),
        .grant      (grant)
    );

    task automatic clr_in();
        thr_en     = '0;
        fetch_num  = '0;
        retire_num = '0;
        flush_en   = '0;
        flush_num  = '0;
        cap_lim    = {NT{4'd15}};
        qsc_req    = '0;
        qsc_addr   = '0;
        st_vld     = 1'b0;
        st_addr    = '0;
    endtask

    task automatic check(input logic [NT-1:0] exp, input string tag);
        checks++;
        if (grant !== exp) begin
            failures++;
            $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr_in();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            clr_in();
            thr_en = VT[v].mask;
            fetch_num[VT[v].ft*FW +: FW]  = VT[v].fn;
            retire_num[VT[v].rt*FW +: FW] = VT[v].rn;
            flush_en[VT[v].flt]           = VT[v].fv;
            flush_num[VT[v].flt*CW +: CW] = VT[v].fln;
            #1;
            check(VT[v].eg, $sformatf("table row %0d (R1 R2 R3 R4 R5 R7 R9)", v));
        end

        // R11: t2 at 3, two fetches of 7 saturate at 15
        @(negedge clk); clr_in(); fetch_num[2*FW +: FW] = 3'd7;
        @(negedge clk); clr_in(); fetch_num[2*FW +: FW] = 3'd7;
        @(negedge clk); clr_in(); thr_en = 4'b0100; retire_num[2*FW +: FW] = 3'd1;
        #1; check(4'b0000, "R11 saturated at cap 15");
        @(negedge clk); clr_in(); thr_en = 4'b0100;
        #1; check(4'b0100, "R11 one below max after retire");

        // R6: t3 holds 5
        @(negedge clk); clr_in(); thr_en = 4'b1000; cap_lim[3*CW +: CW] = 4'd5;
        #1; check(4'b0000, "R6 count equal to cap");
        @(negedge clk); clr_in(); thr_en = 4'b1000; cap_lim[3*CW +: CW] = 4'd6;
        #1; check(4'b1000, "R6 count below cap");

        // R8: quiesce t0 on 0x3C
        @(negedge clk); clr_in(); thr_en = 4'b0001; qsc_req = 4'b0001; qsc_addr = 8'h3C;
        #1; check(4'b0001, "R8 awake in request cycle");
        @(negedge clk); clr_in(); thr_en = 4'b0011; st_vld = 1'b1; st_addr = 8'h11;
        #1; check(4'b0010, "R8 asleep, neighbour wins");
        @(negedge clk); clr_in(); thr_en = 4'b0001; st_vld = 1'b1; st_addr = 8'h3C;
        #1; check(4'b0000, "R8 other address ignored, still asleep");
        @(negedge clk); clr_in(); thr_en = 4'b0001;
        #1; check(4'b0001, "R8 woken by matching store");

        // R1: reset clears counts and rotation
        @(negedge clk); clr_in(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; thr_en = 4'hF;
        #1; check(4'b0001, "R1 first grant after reset");
        for (int i = 0; i < NT; i++) begin
            @(negedge clk); clr_in();
            thr_en = NT'(1) << i;
            cap_lim[i*CW +: CW] = 4'd1;
            #1; check(NT'(1) << i, $sformatf("R1 count zero on thread %0d", i));
        end

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule